// File: doc/BRIEF.md
# Bus Wake-Up Pattern Detector

This block runs while the device sits in a low-power mode. Each clock cycle it samples a one-bit bus state, where 1 means dominant and 0 means recessive. It looks for a remote wake-up pattern made of three phases: a dominant phase, then a recessive phase, then a second dominant phase. Each phase must last a programmable minimum number of consecutive cycles. Pulses shorter than the minimum are treated as glitches. They do not advance the pattern, and they do not undo progress already made.

The time budget starts when the first dominant phase qualifies. If the rest of the pattern does not finish within a programmable number of cycles, the detector returns to its initial state. When the pattern completes, a sticky wake flag is set and the receive-data output, which idles high, is driven low. An explicit clear input drops the flag and restarts the search. An enable input, deasserted outside low-power modes, holds the search in its initial state.

Top module: `bus_wake_detector`

## Requirements
- R1: After reset, `wake_flag` is 0 and `rxd` is 1.
- R2: A dominant phase qualifies on its `dom_min`-th consecutive cycle with `bus_dom`=1. A dominant run shorter than `dom_min` does not advance the pattern, whether it is the first or the third phase.
- R3: With `bus_dom`=1 for `a` cycles, then 0 for `b` cycles, then 1 for `c` cycles, where `a`,`c` ≥ `dom_min`, `b` ≥ `rec_min` and `a`+`b` ≤ `window`, `wake_flag` is seen high after the clock edge that ends cycle `a`+`b`+`dom_min` of the pattern, and not before.
- R4: While the detector waits for the recessive phase, a recessive run shorter than `rec_min` is ignored. The detector keeps waiting for recessive, and a later qualified recessive run still completes the pattern. A short dominant glitch while it waits for the final dominant phase is likewise ignored.
- R5: The window is counted from the cycle after the first dominant phase qualifies. If the pattern has not completed by cycle `window` of that count, the detector returns to its initial state and no wake is produced. For the R3 stimulus this means a wake occurs exactly when `a`+`b` ≤ `window`.
- R6: `rxd` is 1 whenever `wake_flag` is 0, and it is 0 from the cycle the wake event is raised until the flag is cleared.
- R7: `wake_flag` stays set through any bus activity until `clear` is sampled high. It is then 0 after that edge, and the search restarts from its initial state.
- R8: While `enable` is 0, the search is held in its initial state, so a complete pattern driven during that time raises no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | 1 while the device is in a low-power mode; 0 holds the search idle |
| clear | input | 1 | Clears the wake flag and restarts the search |
| bus_dom | input | 1 | Sampled bus state: 1 dominant, 0 recessive |
| dom_min | input | CNT_W | Minimum dominant phase length in cycles |
| rec_min | input | CNT_W | Minimum recessive phase length in cycles |
| window | input | TMO_W | Pattern completion budget in cycles |
| wake_flag | output | 1 | Sticky wake event |
| rxd | output | 1 | Receive data: high until wake, low after |

## Verification
The checker watches, on every cycle, how the flag relates to the other signals. A wake event only arises from a dominant sample while the detector is enabled and not being cleared. The flag holds until a clear, a clear always drops it, and `rxd` falls only as the flag rises.

Some behaviour depends on phase lengths and the timeout budget, and only the bench scenarios can show it. This covers exactly which cycle the flag rises in, whether short runs are filtered out, and whether an over-long pattern is discarded. The bench sweeps all three phase lengths across the boundary of each threshold and predicts every outcome arithmetically.

// File: rtl/wkp_pkg.sv
// Shared types for the bus wake-up pattern detector.
// Assumes: phases are visited strictly in the listed order.
package wkp_pkg;
    typedef enum logic [1:0] {
        PH_FIRST_DOM  = 2'd0,
        PH_GAP_REC    = 2'd1,
        PH_SECOND_DOM = 2'd2,
        PH_HELD       = 2'd3
    } wake_phase_t;
endpackage

// File: rtl/wkp_pulse_filter.sv
// Run-length filter: counts consecutive cycles in which the bus matches the
// level wanted by the current phase, and flags the cycle on which the run
// reaches its minimum. A mismatch zeroes the run, which removes glitches.
// Assumes: min_len of 0 behaves like 1; restart is pulsed on every phase change.
module wkp_pulse_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             bus_dom,
    input  logic             want_dom,
    input  logic [CNT_W-1:0] min_len,
    output logic             qualified
);
    logic [CNT_W-1:0] run_q;
    logic [CNT_W:0]   run_inc;
    logic             match;

    // Compare the current run against the minimum.
    always_comb begin
        match     = (bus_dom == want_dom);
        run_inc   = {1'b0, run_q} + 1'b1;
        qualified = match && (run_inc >= {1'b0, min_len});
    end

    // Advance or zero the run counter; it never exceeds min_len-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (restart || !match || qualified)
            run_q <= '0;
        else
            run_q <= run_inc[CNT_W-1:0];
    end
endmodule

// File: rtl/wkp_window_timer.sv
// Completion-window timer: counts cycles spent after the first dominant phase
// has qualified and signals expiry on the cycle that reaches the limit.
// Assumes: 'active' is high in the cycles counted; 'hold' says the next
// cycle is still inside the window.
module wkp_window_timer #(
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             hold,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] elapsed_q;
    logic [TMO_W:0]   elapsed_inc;

    // Cycle k of the window (elapsed_q = k-1) expires when k >= limit.
    always_comb begin
        elapsed_inc = {1'b0, elapsed_q} + 1'b1;
        expired     = active && (elapsed_inc >= {1'b0, limit});
    end

    // Count while the window stays open, otherwise return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            elapsed_q <= '0;
        else if (active && hold)
            elapsed_q <= elapsed_inc[TMO_W-1:0];
        else
            elapsed_q <= '0;
    end
endmodule

// File: rtl/wkp_phase_seq.sv
// Phase sequencer: steps through first dominant, recessive gap, second
// dominant, then holds. It owns the sticky wake flag. Completion on the
// final qualifying cycle takes priority over window expiry; otherwise expiry
// returns the search to its start.
// Assumes: qualified/expired are combinational from the current phase.
module wkp_phase_seq
    import wkp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        clear,
    input  logic        qualified,
    input  logic        expired,
    output wake_phase_t phase_q,
    output wake_phase_t phase_d,
    output logic        wake_q
);
    logic complete;

    // Choose the next phase.
    always_comb begin
        phase_d  = phase_q;
        complete = 1'b0;
        if (!enable || clear) begin
            phase_d = PH_FIRST_DOM;
        end else begin
            unique case (phase_q)
                PH_FIRST_DOM:  if (qualified) phase_d = PH_GAP_REC;
                PH_GAP_REC: begin
                    if (expired)        phase_d = PH_FIRST_DOM;
                    else if (qualified) phase_d = PH_SECOND_DOM;
                end
                PH_SECOND_DOM: begin
                    if (qualified) begin
                        phase_d  = PH_HELD;
                        complete = 1'b1;
                    end else if (expired) begin
                        phase_d = PH_FIRST_DOM;
                    end
                end
                PH_HELD:       phase_d = PH_HELD;
                default:       phase_d = PH_FIRST_DOM;
            endcase
        end
    end

    // Register the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_FIRST_DOM;
        else        phase_q <= phase_d;
    end

    // Sticky wake flag: set on completion, dropped only by clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        wake_q <= 1'b0;
        else if (clear)    wake_q <= 1'b0;
        else if (complete) wake_q <= 1'b1;
    end
endmodule

// File: rtl/bus_wake_detector.sv
// Top of the bus wake-up pattern detector. It wires one run filter, shared
// by all phases, to the window timer and the phase sequencer. The filter's
// target level and minimum follow the current phase.
// Assumes: bus_dom is already synchronous to clk; thresholds are static
// while a search is in progress.
module bus_wake_detector
    import wkp_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clear,
    input  logic             bus_dom,
    input  logic [CNT_W-1:0] dom_min,
    input  logic [CNT_W-1:0] rec_min,
    input  logic [TMO_W-1:0] window,
    output logic             wake_flag,
    output logic             rxd
);
    wake_phase_t      phase_q;
    wake_phase_t      phase_d;
    logic             want_dom;
    logic [CNT_W-1:0] min_len;
    logic             restart;
    logic             qualified;
    logic             in_window;
    logic             stay_window;
    logic             expired;
    logic             wake_q;

    // Derive filter target, restart and window controls from the phase.
    always_comb begin
        want_dom    = (phase_q != PH_GAP_REC);
        min_len     = want_dom ? dom_min : rec_min;
        restart     = (phase_d != phase_q) || (phase_q == PH_HELD);
        in_window   = (phase_q == PH_GAP_REC) || (phase_q == PH_SECOND_DOM);
        stay_window = (phase_d == PH_GAP_REC) || (phase_d == PH_SECOND_DOM);
    end

    wkp_pulse_filter #(.CNT_W(CNT_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .bus_dom   (bus_dom),
        .want_dom  (want_dom),
        .min_len   (min_len),
        .qualified (qualified)
    );

    wkp_window_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_window),
        .hold    (stay_window),
        .limit   (window),
        .expired (expired)
    );

    wkp_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .clear     (clear),
        .qualified (qualified),
        .expired   (expired),
        .phase_q   (phase_q),
        .phase_d   (phase_d),
        .wake_q    (wake_q)
    );

    // Drive the outputs: receive data idles high and falls with the wake.
    always_comb begin
        wake_flag = wake_q;
        rxd       = ~wake_q;
    end
endmodule

// File: rtl/wkp_checker.sv
// Port-level properties of the wake detector, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module wkp_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic clear,
    input logic bus_dom,
    input logic wake_flag,
    input logic rxd
);
    AST_RISE_ON_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(bus_dom)); // R3

    AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> ($past(enable) && !$past(clear))); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !clear) |=> wake_flag); // R7

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !wake_flag); // R7

    AST_RXD_FALLS_WITH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxd) |-> $rose(wake_flag)); // R6
endmodule

bind bus_wake_detector wkp_checker u_wkp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .clear     (clear),
    .bus_dom   (bus_dom),
    .wake_flag (wake_flag),
    .rxd       (rxd)
);

// File: tb/bus_wake_detector_test.sv
// Sweep bench: dom_min=3, rec_min=2, window=8; all phase lengths a,b,c.
module bus_wake_detector_test;
    localparam int CW = 8;
    localparam int TW = 12;
    localparam int DMIN = 3;
    localparam int RMIN = 2;
    localparam int WIN = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b1;
    logic          clear = 1'b0;
    logic          bus_dom = 1'b0;
    logic [CW-1:0] dom_min = CW'(DMIN);
    logic [CW-1:0] rec_min = CW'(RMIN);
    logic [TW-1:0] window = TW'(WIN);
    logic          wake_flag;
    logic          rxd;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int idx = 0;
    int first_rise = 0;

    bus_wake_detector #(.CNT_W(CW), .TMO_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
        .bus_dom(bus_dom), .dom_min(dom_min), .rec_min(rec_min),
        .window(window), .wake_flag(wake_flag), .rxd(rxd)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Drive one bus cycle and record the first cycle the flag is seen high.
    task automatic tick(input logic v);
        bus_dom = v;
        @(posedge clk);
        #1;
        cyc++;
        idx++;
        if (wake_flag && first_rise == 0) first_rise = idx;
    endtask

    task automatic restart_search();
        clear = 1'b1;
        tick(1'b0);
        clear = 1'b0;
        check(wake_flag == 1'b0, "R7", int'(wake_flag), 0);
        tick(1'b0);
        tick(1'b0);
        idx = 0;
        first_rise = 0;
    endtask

    task automatic drive(input int a, input int b, input int c);
        for (int i = 0; i < a; i++) tick(1'b1);
        for (int i = 0; i < b; i++) tick(1'b0);
        for (int i = 0; i < c; i++) tick(1'b1);
        for (int i = 0; i < 16; i++) tick(1'b0);
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(wake_flag == 1'b0, "R1", int'(wake_flag), 0);
        check(rxd == 1'b1, "R1", int'(rxd), 1);

        // Sweep all phase lengths across every threshold.
        for (int a = 1; a <= 6; a++) begin
            for (int b = 1; b <= 5; b++) begin
                for (int c = 1; c <= 5; c++) begin
                    bit    exp;
                    string tag;
                    restart_search();
                    drive(a, b, c);
                    exp = (a >= DMIN) && (b >= RMIN) && (c >= DMIN) && (a + b <= WIN);
                    if (a < DMIN)           tag = "R2";
                    else if (b < RMIN)      tag = "R4";
                    else if (c < DMIN)      tag = "R2";
                    else if (a + b > WIN)   tag = "R5";
                    else                    tag = "R3";
                    check(wake_flag == exp, tag, int'(wake_flag), int'(exp));
                    if (exp)
                        check(first_rise == a + b + DMIN, "R3", first_rise, a + b + DMIN);
                    check(rxd == !wake_flag, "R6", int'(rxd), int'(!wake_flag));
                end
            end
        end

        // Glitch while waiting for recessive: dom3 rec1 dom1 rec2 dom3.
        restart_search();
        tick(1); tick(1); tick(1); tick(0); tick(1); tick(0); tick(0);
        tick(1); tick(1); tick(1);
        check(first_rise == 10, "R4", first_rise, 10);

        // Glitch while waiting for final dominant: dom3 rec2 dom1 rec1 dom3.
        restart_search();
        tick(1); tick(1); tick(1); tick(0); tick(0); tick(1); tick(0);
        tick(1); tick(1); tick(1);
        check(first_rise == 10, "R4", first_rise, 10);
        check(rxd == 1'b0, "R6", int'(rxd), 0);

        // Flag survives further bus activity until clear.
        drive(4, 3, 4);
        check(wake_flag == 1'b1, "R7", int'(wake_flag), 1);
        clear = 1'b1;
        tick(0);
        clear = 1'b0;
        check(wake_flag == 1'b0, "R7", int'(wake_flag), 0);
        check(rxd == 1'b1, "R6", int'(rxd), 1);

        // Disabled: a full valid pattern must not wake.
        restart_search();
        enable = 1'b0;
        drive(3, 2, 3);
        check(wake_flag == 1'b0, "R8", int'(wake_flag), 0);
        enable = 1'b1;
        restart_search();
        drive(3, 2, 3);
        check(wake_flag == 1'b1, "R8", int'(wake_flag), 1);

        report();
    end
endmodule